// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the single global operation register shared by all channels of a multi-channel DMA controller. It holds a master enable bit, which software reads and writes freely, and two sticky error flags: one raised by the DMA logic's address-error report and one raised by each non-maskable interrupt edge. From these bits and from each channel's own enable and transfer-end status, it produces a registered per-channel transfer-permit vector. The channel engines consume this vector.

Software reaches the register through a simple decoded port: a read strobe, a write strobe, write data and combinational read data. Neither flag can be set by software. A flag clears only through a two-step handshake: a read that returns the flag as 1 arms a per-flag marker, and the next write then clears the flag if it carries 0 in that bit. Every write consumes the markers, whatever data it carries. A power-on reset and a manual reset each return the whole register to zero. Both resets are synchronous and active-low.

Top module: `dma_global_ctrl`

## Requirements
- R1: While power-on reset `rst_n` is low, and in the cycle after it, read data is all zeros and `ch_permit` is all zeros.
- R2: A manual reset (`mrst_n` low for one edge) clears the master enable, both flags and both read-armed markers. After it, a 0-write to a flag that was set again leaves that flag at 1.
- R3: Register layout: bit 0 is the master enable (read/write), bit 1 is the NMI flag and bit 2 is the address-error flag. All other bits read as 0.
- R4: A cycle with `addr_err_evt` high sets the address-error flag at that edge, whatever the master enable holds.
- R5: A cycle with `nmi_evt` high sets the NMI flag at that edge, including while the master enable is 0.
- R6: Writing 1 to a flag bit never sets that flag.
- R7: Writing 0 to a set flag leaves it at 1 unless a read since the previous write returned that flag as 1.
- R8: Writing 0 to a flag after a read that returned it as 1 clears it at that write's edge. The marker is per bit: the marker of a flag that read as 0 is not armed. Every write consumes both markers, so a second 0-write needs a fresh read.
- R9: When a flag's set event and a valid software clear hit the same edge, the flag stays 1.
- R10: `ch_permit[n]` equals master enable AND `ch_en[n]` AND NOT `ch_end[n]` AND NOT either flag, registered one edge after the register state and the inputs it samples.
- R11: Writing 0 to the master enable while channels are permitted drops every bit of `ch_permit` one edge after the write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| reg_rd | input | 1 | Decoded register read strobe |
| reg_wr | input | 1 | Decoded register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Current register contents |
| addr_err_evt | input | 1 | Address error reported by the DMA logic |
| nmi_evt | input | 1 | NMI edge pulse |
| ch_en | input | NUM_CH | Per-channel enable bits |
| ch_end | input | NUM_CH | Per-channel transfer-end bits |
| ch_permit | output | NUM_CH | Registered per-channel transfer permit |

## Verification
The embedded properties check the cycle-level rules on every cycle. An event always leaves its flag set on the next edge. A clear flag stays clear unless an event arrives. A set flag with no armed marker survives any write. A raised flag, or a master enable of 0, forces the permit vector to zero on the next edge, and no channel is permitted unless it was enabled and not ended one edge earlier. Only the bench scenarios show the full software handshake: the read-then-write order, marker consumption by an intervening write, per-bit arming, equal treatment of the two resets, and the exact permit value across every combination of enable, end and flag state.

// File: rtl/dmag_pkg.sv
// Package: shared constants for the DMA global control register.
// Bit positions are software-visible and must stay fixed.
package dmag_pkg;
    localparam int unsigned BIT_ME   = 0;  // master enable
    localparam int unsigned BIT_NMI  = 1;  // NMI flag
    localparam int unsigned BIT_AE   = 2;  // address-error flag
    localparam int unsigned FLAG_CNT = 2;  // flags start at BIT_NMI
    localparam int unsigned USED_W   = 3;
endpackage

// File: rtl/dmag_sticky.sv
// Module: dmag_sticky
// One hardware-set, software-cleared sticky flag with a read-armed marker.
// Assumes: rd_i/wr_i are single-cycle decoded strobes; clr_n is the
// combined synchronous active-low reset. A set event beats a clear.
module dmag_sticky (
    input  logic clk,
    input  logic clr_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o
);
    logic arm_q;
    logic clr_ok;

    // Purpose: a valid clear needs an armed marker and a 0 in the written bit.
    assign clr_ok = wr_i && arm_q && !wbit_i;

    // Purpose: flag register, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!clr_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_ok) q_o <= 1'b0;
    end

    // Purpose: marker arms on a read that sees 1 and is consumed by any write.
    always_ff @(posedge clk) begin
        if (!clr_n)             arm_q <= 1'b0;
        else if (rd_i && q_o)   arm_q <= 1'b1;
        else if (wr_i)          arm_q <= 1'b0;
    end

    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!clr_n)
        set_i |=> (!clr_n || q_o));
    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (!q_o && !set_i) |=> (!clr_n || !q_o));
    assert_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (q_o && !arm_q) |=> (!clr_n || q_o));
endmodule

// File: rtl/dmag_gate.sv
// Module: dmag_gate
// Registered per-channel transfer permit.
// Assumes: me_i and halt_i come from registers; halt_i is the OR of all flags.
module dmag_gate #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              me_i,
    input  logic              halt_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] end_i,
    output logic [NUM_CH-1:0] permit_o
);
    logic global_ok;

    // Purpose: one global qualifier shared by every channel.
    assign global_ok = me_i && !halt_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Purpose: register the permit for channel c.
        always_ff @(posedge clk) begin
            if (!clr_n) permit_o[c] <= 1'b0;
            else        permit_o[c] <= global_ok && en_i[c] && !end_i[c];
        end

        assert_permit_needs_chan_R10: assert property (@(posedge clk) disable iff (!clr_n)
            permit_o[c] |-> ($past(en_i[c]) && !$past(end_i[c])));
    end

    assert_flag_blocks_R10: assert property (@(posedge clk) disable iff (!clr_n)
        halt_i |=> (!clr_n || permit_o == '0));
    assert_me_off_stops_R11: assert property (@(posedge clk) disable iff (!clr_n)
        !me_i |=> (!clr_n || permit_o == '0));
endmodule

// File: rtl/dma_global_ctrl.sv
// Module: dma_global_ctrl
// Global DMA operation register: master enable, NMI and address-error
// sticky flags, and the per-channel transfer permit vector.
// Assumes: both resets synchronous active-low; strobes pre-decoded.
module dma_global_ctrl #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              addr_err_evt,
    input  logic              nmi_evt,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_end,
    output logic [NUM_CH-1:0] ch_permit
);
    import dmag_pkg::*;

    localparam int unsigned NF = FLAG_CNT;

    logic          clr_n;
    logic          me_q;
    logic [NF-1:0] flag_set;
    logic [NF-1:0] flag_q;

    // Purpose: either reset clears the whole register.
    assign clr_n = rst_n && mrst_n;

    // Purpose: flag k sits at bit BIT_NMI+k; NMI first, address error second.
    assign flag_set = {addr_err_evt, nmi_evt};

    // Purpose: plain read/write master enable.
    always_ff @(posedge clk) begin
        if (!clr_n)      me_q <= 1'b0;
        else if (reg_wr) me_q <= reg_wdata[BIT_ME];
    end

    for (genvar k = 0; k < NF; k++) begin : g_flag
        dmag_sticky u_flag (
            .clk    (clk),
            .clr_n  (clr_n),
            .set_i  (flag_set[k]),
            .rd_i   (reg_rd),
            .wr_i   (reg_wr),
            .wbit_i (reg_wdata[BIT_NMI+k]),
            .q_o    (flag_q[k])
        );
    end

    // Purpose: assemble read data; unused bits are zero.
    always_comb begin
        reg_rdata          = '0;
        reg_rdata[BIT_ME]  = me_q;
        reg_rdata[BIT_NMI] = flag_q[0];
        reg_rdata[BIT_AE]  = flag_q[1];
    end

    dmag_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk      (clk),
        .clr_n    (clr_n),
        .me_i     (me_q),
        .halt_i   (|flag_q),
        .en_i     (ch_en),
        .end_i    (ch_end),
        .permit_o (ch_permit)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && ch_permit == '0));
    assert_mreset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mrst_n |=> (!rst_n || reg_rdata == '0));
endmodule

// File: tb/test_dma_global_ctrl.sv
module test_dma_global_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0, mrst_n = 1'b1;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic addr_err_evt = 1'b0, nmi_evt = 1'b0;
    logic [NCH-1:0] ch_en = '0, ch_end = '0;
    logic [NCH-1:0] ch_permit;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    dma_global_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) i_dma_global_ctrl (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt),
        .ch_en(ch_en), .ch_end(ch_end), .ch_permit(ch_permit)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(output logic [DW-1:0] d);
        reg_rd = 1'b1; d = reg_rdata; tick(); reg_rd = 1'b0;
    endtask

    task automatic pulse_ae();
        addr_err_evt = 1'b1; tick(); addr_err_evt = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_evt = 1'b1; tick(); nmi_evt = 1'b0;
    endtask

    task automatic mreset();
        mrst_n = 1'b0; tick(); mrst_n = 1'b1;
    endtask

    initial begin
        #800000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        #1;
        tick(); tick();
        check("R1 rdata in reset", reg_rdata, 0);
        ch_en = '1;
        rst_n = 1'b1; tick();
        check("R1 rdata after reset", reg_rdata, 0);
        check("R1 permit after reset", {28'd0, ch_permit}, 0);

        // R3: layout and upper bits
        wr('1);
        check("R3 only enable writable", reg_rdata, 32'h1);
        wr(32'h0);
        check("R3 enable written 0", reg_rdata, 32'h0);

        // R5: NMI sets while master enable is 0
        pulse_nmi();
        check("R5 nmi sets bit1", reg_rdata, 32'h2);
        // R4: address error sets bit2
        wr(32'h1);
        pulse_ae();
        check("R4 ae sets bit2", reg_rdata, 32'h7);
        // R6: writing 1 to flags after clear attempt path: start clean
        mreset();
        wr(32'h6);
        check("R6 write 1 sets no flag", reg_rdata, 32'h0);

        // R7: 0-write without read
        pulse_ae(); pulse_nmi();
        wr(32'h0);
        check("R7 unread flags stay", reg_rdata, 32'h6);
        // R7: read, then intervening write, then 0-write
        rd(d);
        check("R3 read value", d, 32'h6);
        wr(32'h6);
        check("R6 write 1 keeps flags", reg_rdata, 32'h6);
        wr(32'h0);
        check("R7 marker consumed", reg_rdata, 32'h6);
        // R8: proper handshake
        rd(d);
        wr(32'h0);
        check("R8 handshake clears both", reg_rdata, 32'h0);
        // R8: per-bit arming
        pulse_ae();
        rd(d);
        pulse_nmi();
        wr(32'h0);
        check("R8 only armed flag clears", reg_rdata, 32'h2);
        rd(d); wr(32'h0);
        check("R8 nmi cleared", reg_rdata, 32'h0);
        // R8: clear only the written-0 flag
        pulse_ae(); pulse_nmi();
        rd(d); wr(32'h2);
        check("R8 bit1=1 keeps nmi", reg_rdata, 32'h2);

        // R9: set beats clear
        mreset();
        pulse_ae();
        rd(d);
        addr_err_evt = 1'b1; wr(32'h0); addr_err_evt = 1'b0;
        check("R9 set wins", reg_rdata, 32'h4);
        rd(d); wr(32'h0);
        check("R9 later clear works", reg_rdata, 32'h0);

        // R2: manual reset clears everything, including markers
        wr(32'h1); pulse_nmi(); pulse_ae(); rd(d);
        ch_en = '1; ch_end = '0;
        mreset();
        check("R2 rdata cleared", reg_rdata, 0);
        check("R2 permit cleared", {28'd0, ch_permit}, 0);
        pulse_nmi();
        wr(32'h0);
        check("R2 marker cleared", reg_rdata, 32'h2);

        // R11: dropping master enable
        mreset();
        wr(32'h1); ch_en = '1; ch_end = '0; tick();
        check("R11 permitted before", {28'd0, ch_permit}, 32'hF);
        wr(32'h0);
        check("R11 still permitted at write edge", {28'd0, ch_permit}, 32'hF);
        tick();
        check("R11 all stopped", {28'd0, ch_permit}, 0);

        // R10: sweep of all states and channel inputs
        for (int s = 0; s < 8; s++) begin
            mreset();
            wr({31'd0, s[0]});
            if (s[1]) pulse_nmi();
            if (s[2]) pulse_ae();
            for (int v = 0; v < 256; v++) begin
                logic [NCH-1:0] exp;
                ch_en = v[3:0]; ch_end = v[7:4];
                tick();
                exp = (s[0] && !s[1] && !s[2]) ? (v[3:0] & ~v[7:4]) : '0;
                check("R10 permit", {28'd0, ch_permit}, {28'd0, exp});
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule